// File: doc/BRIEF.md
# Endpoint Configuration Header with 64-bit Memory Window Sizing

This block holds the standard configuration header of a single endpoint function. A configuration agent sends it dword-sized read and write requests at byte offsets inside a 256-byte space, with a byte-enable nibble per request. The block keeps the writable state itself: two command bits and a 64-bit memory base split over two consecutive dword registers. Identity values (vendor, device, revision, class code) and the pointer to the first capability are fixed by parameters and cannot be written.

The memory window supports the usual sizing handshake. Address bits below the window size are tied off, so after software writes all ones to the base pair it reads back a mask from which it can work out the size. The low nibble of the low base register always shows the window attributes: memory type, 64-bit decoder and the prefetch flag. The function logic uses the decoded base address, the memory-decode enable, a bus-master permission line, and a combinational `hit` that says whether an incoming address falls inside the programmed window.

Requests use a valid/ready channel. Responses go back on a second valid/ready channel, and only reads produce a response. The block holds one response. A new request is taken only when that slot is empty or is being drained in the same cycle, so back-pressure on the response side stalls the request side.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset the command bits, both base registers, `mem_enable`, `dma_allowed`, `bar_base`, `hit` and `rsp_valid` are all zero.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` equals `!rsp_valid || rsp_ready`. An accepted read shows its data with `rsp_valid` high from the next cycle, and `rsp_rdata` stays unchanged while `rsp_valid` is high and `rsp_ready` is low. Bits [7:2] of `req_addr` select the dword and bits [1:0] are ignored.
- R3: Dword 0x00 reads `{DEVICE_ID, VENDOR_ID}` and dword 0x08 reads `{CLASS_CODE, REVISION}`, with the class code in bits [31:8]. Writes to either dword have no effect.
- R4: Dword 0x34 reads `CAP_PTR` in bits [7:0] and zero above. In dword 0x04, bit 20 (the capability-list status flag) reads 1 exactly when `CAP_PTR` is nonzero.
- R5: In dword 0x04, bit 1 is the memory-decode enable and drives `mem_enable`. Bit 2 is the bus-master enable and drives `dma_allowed`. Only a write with `req_be[0]` set changes them. All other bits of the command half read 0.
- R6: The low dword of the base (0x10) always reads bit 0 = 0, bits [2:1] = 2'b10 and bit 3 = `PREFETCH`, and reads bits [SIZE_LOG2-1:4] as 0, whatever was written.
- R7: Writing 0xFFFFFFFF to 0x10 makes it read back `~(2^SIZE_LOG2-1)` combined with the attribute nibble. Writing 0xFFFFFFFF to 0x14 makes it read back 0xFFFFFFFF.
- R8: A write changes only the byte lanes whose `req_be` bit is set. A write that does not address a base register leaves `bar_base` unchanged.
- R9: `bar_base` equals {dword 0x14, writable bits of dword 0x10}, and its bits [SIZE_LOG2-1:0] are 0.
- R10: `hit` is high when `mem_enable` is set and `probe_addr[63:SIZE_LOG2]` equals `bar_base[63:SIZE_LOG2]`, and low otherwise, in the same cycle as `probe_addr`.
- R11: Every dword other than 0x00, 0x04, 0x08, 0x10, 0x14 and 0x34 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset in the configuration space |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| probe_addr | input | 64 | Address tested against the memory window |
| hit | output | 1 | Address inside the enabled window |
| bar_base | output | 64 | Decoded window base address |
| mem_enable | output | 1 | Memory-decode enable |
| dma_allowed | output | 1 | Function may issue memory requests |

## Verification
The bound checker watches the handshake rules on every cycle: a held response keeps its data, and a request stalls while a response is blocked. It also checks every cycle that the attribute nibble and class code read back fixed, that the bus-master line follows the last command write, that `hit` never rises with decode disabled, and that the base stays put when no base write is accepted. Only the bench scenarios show the actual sizing mask after an all-ones write and the effect of individual byte lanes. They also show that identity and unused offsets ignore writes, and where the window boundaries fall for `hit` under a real programmed base.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int DW_IDX_W = 6;

  localparam logic [DW_IDX_W-1:0] DW_IDENT = 6'd0;
  localparam logic [DW_IDX_W-1:0] DW_CMD   = 6'd1;
  localparam logic [DW_IDX_W-1:0] DW_CLASS = 6'd2;
  localparam logic [DW_IDX_W-1:0] DW_WINLO = 6'd4;
  localparam logic [DW_IDX_W-1:0] DW_WINHI = 6'd5;
  localparam logic [DW_IDX_W-1:0] DW_CAPP  = 6'd13;

  localparam int CMD_MEM_BIT  = 1;
  localparam int CMD_MAST_BIT = 2;
  localparam int STS_CAP_BIT  = 20;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic lane0_en,
  input  logic mem_bit_in,
  input  logic mast_bit_in,
  output logic mem_en,
  output logic mast_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_en  <= 1'b0;
      mast_en <= 1'b0;
    end else if (wr_en && lane0_en) begin
      mem_en  <= mem_bit_in;
      mast_en <= mast_bit_in;
    end
  end
endmodule

// File: rtl/cfg_bar64.sv
module cfg_bar64 #(
  parameter int SIZE_LOG2 = 12,
  parameter bit PREFETCH  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] be_mask,
  input  logic [31:0] wdata,
  output logic [31:0] lo_rd,
  output logic [31:0] hi_rd,
  output logic [63:0] base
);
  localparam logic [31:0] WIN_WMASK = ~((32'd1 << SIZE_LOG2) - 32'd1);
  localparam logic [31:0] WIN_ATTR  = {28'd0, PREFETCH, 2'b10, 1'b0};

  logic [31:0] lo_q, hi_q;
  logic [31:0] lo_m;

  assign lo_m = be_mask & WIN_WMASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= (lo_q & ~lo_m) | (wdata & lo_m);
      if (wr_hi) hi_q <= (hi_q & ~be_mask) | (wdata & be_mask);
    end
  end

  assign lo_rd = lo_q | WIN_ATTR;
  assign hi_rd = hi_q;
  assign base  = {hi_q, lo_q};
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID  = 16'h0042,
  parameter logic [7:0]  REVISION   = 8'h01,
  parameter logic [23:0] CLASS_CODE = 24'h010802,
  parameter logic [7:0]  CAP_PTR    = 8'h40
) (
  input  logic [DW_IDX_W-1:0] idx,
  input  logic                mem_en,
  input  logic                mast_en,
  input  logic [31:0]         win_lo,
  input  logic [31:0]         win_hi,
  output logic [31:0]         rdata
);
  localparam logic CAP_PRESENT = (CAP_PTR != 8'd0);

  logic [31:0] cmd_word;

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_MEM_BIT]  = mem_en;
    cmd_word[CMD_MAST_BIT] = mast_en;
    cmd_word[STS_CAP_BIT]  = CAP_PRESENT;
  end

  always_comb begin
    case (idx)
      DW_IDENT: rdata = {DEVICE_ID, VENDOR_ID};
      DW_CMD:   rdata = cmd_word;
      DW_CLASS: rdata = {CLASS_CODE, REVISION};
      DW_WINLO: rdata = win_lo;
      DW_WINHI: rdata = win_hi;
      DW_CAPP:  rdata = {24'd0, CAP_PTR};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID  = 16'h0042,
  parameter logic [7:0]  REVISION   = 8'h01,
  parameter logic [23:0] CLASS_CODE = 24'h010802,
  parameter logic [7:0]  CAP_PTR    = 8'h40,
  parameter int          SIZE_LOG2  = 12,
  parameter bit          PREFETCH   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  input  logic [63:0] probe_addr,
  output logic        hit,
  output logic [63:0] bar_base,
  output logic        mem_enable,
  output logic        dma_allowed
);
  logic [DW_IDX_W-1:0] idx;
  logic                accept, wr_acc;
  logic [31:0]         be_mask;
  logic [31:0]         win_lo, win_hi, mux_data;
  logic                rsp_q;
  logic [31:0]         rdata_q;

  assign idx     = req_addr[7:2];
  assign accept  = req_valid && req_ready;
  assign wr_acc  = accept && req_write;
  assign be_mask = lane_mask(req_be);

  cfg_cmd_reg u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_acc && (idx == DW_CMD)),
    .lane0_en   (req_be[0]),
    .mem_bit_in (req_wdata[CMD_MEM_BIT]),
    .mast_bit_in(req_wdata[CMD_MAST_BIT]),
    .mem_en     (mem_enable),
    .mast_en    (dma_allowed)
  );

  cfg_bar64 #(.SIZE_LOG2(SIZE_LOG2), .PREFETCH(PREFETCH)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_lo  (wr_acc && (idx == DW_WINLO)),
    .wr_hi  (wr_acc && (idx == DW_WINHI)),
    .be_mask(be_mask),
    .wdata  (req_wdata),
    .lo_rd  (win_lo),
    .hi_rd  (win_hi),
    .base   (bar_base)
  );

  cfg_read_mux #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .REVISION  (REVISION),
    .CLASS_CODE(CLASS_CODE),
    .CAP_PTR   (CAP_PTR)
  ) u_mux (
    .idx    (idx),
    .mem_en (mem_enable),
    .mast_en(dma_allowed),
    .win_lo (win_lo),
    .win_hi (win_hi),
    .rdata  (mux_data)
  );

  // one-entry response slot
  assign req_ready = !rsp_q || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else if (accept && !req_write) begin
      rsp_q   <= 1'b1;
      rdata_q <= mux_data;
    end else if (rsp_ready) begin
      rsp_q   <= 1'b0;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  assign hit = mem_enable && (probe_addr[63:SIZE_LOG2] == bar_base[63:SIZE_LOG2]);
endmodule

// File: rtl/cfg_header_regs_chk.sv
module cfg_header_regs_chk #(
  parameter logic [23:0] CLASS_CODE = 24'h010802,
  parameter int          SIZE_LOG2  = 12,
  parameter bit          PREFETCH   = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [7:0]  req_addr,
  input logic [3:0]  req_be,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        hit,
  input logic [63:0] bar_base,
  input logic        mem_enable,
  input logic        dma_allowed
);
  localparam logic [31:0] LOW_MASK = (32'd1 << SIZE_LOG2) - 32'd1;
  localparam logic [31:0] ATTR     = {28'd0, PREFETCH, 2'b10, 1'b0};

  logic rd_acc, cmd_wr, win_wr;
  assign rd_acc = req_valid && req_ready && !req_write;
  assign cmd_wr = req_valid && req_ready && req_write && (req_addr[7:2] == 6'd1) && req_be[0];
  assign win_wr = req_valid && req_ready && req_write &&
                  ((req_addr[7:2] == 6'd4) || (req_addr[7:2] == 6'd5));

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_class_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && (req_addr[7:2] == 6'd2) |=> rsp_valid && (rsp_rdata[31:8] == CLASS_CODE));

  p_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> dma_allowed == $past(req_wdata[2]));

  p_attr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && (req_addr[7:2] == 6'd4) |=> rsp_valid && ((rsp_rdata & LOW_MASK) == ATTR));

  p_base_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> $stable(bar_base));

  p_hit_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> mem_enable);
endmodule

bind cfg_header_regs cfg_header_regs_chk #(
  .CLASS_CODE(CLASS_CODE),
  .SIZE_LOG2 (SIZE_LOG2),
  .PREFETCH  (PREFETCH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_be     (req_be),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .hit        (hit),
  .bar_base   (bar_base),
  .mem_enable (mem_enable),
  .dma_allowed(dma_allowed)
);

// File: tb/cfg_header_regs_test.sv
module cfg_header_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] T_VID   = 16'hA5C3;
  localparam logic [15:0] T_DID   = 16'h0042;
  localparam logic [7:0]  T_REV   = 8'h01;
  localparam logic [23:0] T_CLASS = 24'h010802;
  localparam logic [7:0]  T_CAP   = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic [63:0] probe_addr = '0;
  logic        req_ready, rsp_valid, hit, mem_enable, dma_allowed;
  logic [31:0] rsp_rdata;
  logic [63:0] bar_base;

  int checks = 0, errors = 0, cyc = 0;
  bit stall = 0, hold = 0, done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_header_regs #(
    .VENDOR_ID(T_VID), .DEVICE_ID(T_DID), .REVISION(T_REV),
    .CLASS_CODE(T_CLASS), .CAP_PTR(T_CAP), .SIZE_LOG2(12), .PREFETCH(1'b0)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .probe_addr(probe_addr), .hit(hit),
    .bar_base(bar_base), .mem_enable(mem_enable), .dma_allowed(dma_allowed)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: sets rsp_ready for the coming edge and scores handshakes
  always @(negedge clk) begin
    cyc++;
    rsp_ready = hold ? 1'b0 : (stall ? (cyc % 3 != 0) : 1'b1);
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk("R2 unexpected response", {32'd0, rsp_rdata}, 64'd0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {32'd0, rsp_rdata}, {32'd0, e});
      end
    end
  end

  task automatic access(input bit wr, input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    access(1'b0, a, 4'h0, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    access(1'b1, a, be, d);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mem_enable", {63'd0, mem_enable}, 64'd0);
    chk("R1 dma_allowed", {63'd0, dma_allowed}, 64'd0);
    chk("R1 bar_base", bar_base, 64'd0);
    chk("R1 hit", {63'd0, hit}, 64'd0);
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);

    rd(8'h00, {T_DID, T_VID}, "R3 ident");
    rd(8'h08, {T_CLASS, T_REV}, "R3 class");
    rd(8'h34, {24'd0, T_CAP}, "R4 cap ptr");
    rd(8'h04, 32'h0010_0000, "R4 status cap flag");
    rd(8'h10, 32'h0000_0004, "R6 attr after reset");
    rd(8'h14, 32'h0, "R1 win hi reset");
    rd(8'hFC, 32'h0, "R11 unused read");
    rd(8'h0B, {T_CLASS, T_REV}, "R2 low addr bits ignored");

    wr(8'h00, 4'hF, 32'hFFFF_FFFF);
    wr(8'h08, 4'hF, 32'hFFFF_FFFF);
    wr(8'h34, 4'hF, 32'hFFFF_FFFF);
    wr(8'h80, 4'hF, 32'hFFFF_FFFF);
    rd(8'h00, {T_DID, T_VID}, "R3 ident write ignored");
    rd(8'h08, {T_CLASS, T_REV}, "R3 class write ignored");
    rd(8'h34, {24'd0, T_CAP}, "R4 cap write ignored");
    rd(8'h80, 32'h0, "R11 unused write ignored");
    drain();
    chk("R8 base unchanged by other writes", bar_base, 64'd0);

    // sizing
    wr(8'h10, 4'hF, 32'hFFFF_FFFF);
    wr(8'h14, 4'hF, 32'hFFFF_FFFF);
    rd(8'h10, 32'hFFFF_F004, "R7 size mask lo");
    rd(8'h14, 32'hFFFF_FFFF, "R7 size mask hi");
    drain();
    chk("R9 base after sizing", bar_base, 64'hFFFF_FFFF_FFFF_F000);

    // byte lanes
    wr(8'h10, 4'b1000, 32'h1234_5678);
    wr(8'h14, 4'b0101, 32'hAABB_CCDD);
    rd(8'h10, 32'h12FF_F004, "R8 lane write lo");
    rd(8'h14, 32'hFFBB_FFDD, "R8 lane write hi");

    wr(8'h10, 4'hF, 32'h8765_4ABC);
    wr(8'h14, 4'hF, 32'h0000_0001);
    rd(8'h10, 32'h8765_4004, "R6 low bits dropped");
    drain();
    chk("R9 programmed base", bar_base, 64'h0000_0001_8765_4000);

    // command register
    wr(8'h04, 4'b0010, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R5 lane1 no effect mem", {63'd0, mem_enable}, 64'd0);
    chk("R5 lane1 no effect dma", {63'd0, dma_allowed}, 64'd0);
    probe_addr = 64'h0000_0001_8765_4FFF;
    #1 chk("R10 hit with decode off", {63'd0, hit}, 64'd0);

    wr(8'h04, 4'b0001, 32'h0000_0002);
    @(negedge clk);
    chk("R5 mem_enable set", {63'd0, mem_enable}, 64'd1);
    chk("R5 dma still off", {63'd0, dma_allowed}, 64'd0);
    probe_addr = 64'h0000_0001_8765_4FFF;
    #1 chk("R10 hit top of window", {63'd0, hit}, 64'd1);
    probe_addr = 64'h0000_0001_8765_4000;
    #1 chk("R10 hit base of window", {63'd0, hit}, 64'd1);
    probe_addr = 64'h0000_0001_8765_5000;
    #1 chk("R10 miss above window", {63'd0, hit}, 64'd0);
    probe_addr = 64'h0000_0000_8765_4000;
    #1 chk("R10 miss upper dword", {63'd0, hit}, 64'd0);
    rd(8'h04, 32'h0010_0002, "R5 command read mem");

    wr(8'h04, 4'b0001, 32'h0000_0004);
    @(negedge clk);
    chk("R5 dma_allowed set", {63'd0, dma_allowed}, 64'd1);
    chk("R5 mem_enable cleared", {63'd0, mem_enable}, 64'd0);
    probe_addr = 64'h0000_0001_8765_4100;
    #1 chk("R10 no hit decode cleared", {63'd0, hit}, 64'd0);
    wr(8'h04, 4'b0011, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0010_0006, "R5 other command bits zero");
    drain();

    // back-pressure
    hold = 1'b1;
    rd(8'h00, {T_DID, T_VID}, "R2 held response data");
    @(negedge clk); #1;
    chk("R2 rsp_valid while held", {63'd0, rsp_valid}, 64'd1);
    chk("R2 req_ready low while held", {63'd0, req_ready}, 64'd0);
    hold = 1'b0;
    stall = 1'b1;
    rd(8'h08, {T_CLASS, T_REV}, "R2 stall class");
    rd(8'h10, 32'h8765_4004, "R2 stall win lo");
    rd(8'h14, 32'h0000_0001, "R2 stall win hi");
    rd(8'h34, {24'd0, T_CAP}, "R2 stall cap");
    rd(8'h40, 32'h0, "R2 stall unused");
    drain();
    stall = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule